// File: doc/BRIEF.md
# Thermal Fault Alert Latch

This block turns the fault flags of a temperature monitor into one latched alert request for a shared, active-low, open-drain interrupt line. Three fault sources feed it: a reading above the upper limit, a reading below the lower limit, and an open or disconnected sensing diode. A configuration bit gates whether a fault may raise the alert. Once raised, the alert stays up until the bus controller polls the shared alert-response address. That poll clears the alert only when every fault has gone away.

Next to the alert, the block keeps one sticky status bit per fault source. A status register read clears these bits. Status reads and the alert latch have no effect on each other. While the alert is up, the block supplies the byte it returns on the alert-response read: its own 7-bit bus address followed by a 0. The serial protocol engine, address matching and temperature conversion sit outside this block. They feed it one-cycle pulses that mark a finished alert-response read and a finished status read.

Top module: `thermal_alert_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `alert_pull_o` is 0, `status_o` is all zeros and `ara_byte_o` is 8'hFF.
- R2: A cycle in which `irq_en_i` is 1 and any bit of `fault_i` is 1 makes `alert_pull_o` 1 after the next rising clock edge.
- R3: Once `alert_pull_o` is 1, it stays 1 for as long as no alert-response read pulse (`ara_rd_i`) arrives. This holds even if the faults go away, `irq_en_i` falls, or a status read occurs.
- R4: An `ara_rd_i` pulse in a cycle where the alert is 1 and every `fault_i` bit is 0 makes `alert_pull_o` 0 after the next edge.
- R5: An `ara_rd_i` pulse in a cycle where the alert is 1 and any `fault_i` bit is 1 leaves `alert_pull_o` at 1. This holds whatever `irq_en_i` is.
- R6: While `irq_en_i` is 0, faults do not raise an alert that is not already latched. An `ara_rd_i` pulse while the alert is 0 does not raise it either.
- R7: The bits of `status_o` map to sources as follows: bit 0 is the upper-limit fault, bit 1 is the lower-limit fault and bit 2 is the open-diode fault. Each bit is set one cycle after its `fault_i` bit is 1, whatever `irq_en_i` is. It stays set until a status read.
- R8: A `stat_rd_i` pulse sets `status_o` on the next edge to the `fault_i` value present in the read cycle. Bits whose source is inactive are cleared.
- R9: `ara_byte_o` equals {`dev_addr_i`, 1'b0} while `alert_pull_o` is 1, and 8'hFF while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | N_SRC (3) | Fault levels: bit 0 upper limit, bit 1 lower limit, bit 2 open diode |
| irq_en_i | input | 1 | Interrupt enable from configuration (0 = masked) |
| ara_rd_i | input | 1 | One-cycle pulse: alert-response read completed |
| stat_rd_i | input | 1 | One-cycle pulse: status register read completed |
| dev_addr_i | input | ADDR_W (7) | This device's bus address |
| alert_pull_o | output | 1 | 1 = drive the open-drain alert line low |
| status_o | output | N_SRC (3) | Sticky per-source fault status |
| ara_byte_o | output | ADDR_W+1 (8) | Byte returned on the alert-response read |

## Verification
The assertions assume that `ara_rd_i` and `stat_rd_i` are single-cycle pulses that the protocol engine produces. They also assume that `fault_i` and `irq_en_i` are synchronous levels that hold steady between rising edges. The stimulus changes every input only on the falling edge and holds each read strobe high for exactly one cycle. It also keeps `dev_addr_i` constant except in one deliberate step while the alert is latched. With these inputs, the one-cycle properties on latch set, hold, clear and status stickiness are well defined at every edge after reset.

// File: rtl/thalert_pkg.sv
package thalert_pkg;
  // bit positions of the fault sources inside fault_i / status_o
  localparam int SRC_HI   = 0;
  localparam int SRC_LO   = 1;
  localparam int SRC_OPEN = 2;

  // next state of the alert latch
  function automatic logic latch_next(input logic latched, input logic any_fault,
                                      input logic enable, input logic ara_rd);
    logic set_evt;
    set_evt = enable & any_fault;
    if (ara_rd && latched)
      return any_fault;          // clears only when nothing is still faulting
    return latched | set_evt;
  endfunction

  // next state of one sticky status bit
  function automatic logic sticky_next(input logic cur, input logic src, input logic rd);
    return rd ? src : (cur | src);
  endfunction
endpackage

// File: rtl/thalert_status.sv
module thalert_status #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             rd_i,
  output logic [N_SRC-1:0] stat_o
);
  import thalert_pkg::*;

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= sticky_next(bit_q, src_i[g], rd_i);
    end
    assign stat_o[g] = bit_q;
  end
endmodule

// File: rtl/thalert_latch.sv
module thalert_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic any_i,
  input  logic en_i,
  input  logic ara_i,
  output logic alert_o,
  output logic set_evt_o,
  output logic clr_evt_o
);
  import thalert_pkg::*;

  logic alert_q;

  assign set_evt_o = en_i & any_i & ~alert_q;
  assign clr_evt_o = ara_i & alert_q & ~any_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_q <= 1'b0;
    else        alert_q <= latch_next(alert_q, any_i, en_i, ara_i);
  end

  assign alert_o = alert_q;
endmodule

// File: rtl/thalert_resp.sv
module thalert_resp #(
  parameter int ADDR_W = 7
) (
  input  logic              latched_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W:0]   byte_o
);
  always_comb begin
    if (latched_i) byte_o = {addr_i, 1'b0};
    else           byte_o = '1;
  end
endmodule

// File: rtl/thermal_alert_ctl.sv
module thermal_alert_ctl #(
  parameter int N_SRC  = 3,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  fault_i,
  input  logic              irq_en_i,
  input  logic              ara_rd_i,
  input  logic              stat_rd_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              alert_pull_o,
  output logic [N_SRC-1:0]  status_o,
  output logic [ADDR_W:0]   ara_byte_o
);
  logic fault_any;
  logic set_evt;
  logic clr_evt;

  assign fault_any = |fault_i;

  thalert_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_i    (fault_any),
    .en_i     (irq_en_i),
    .ara_i    (ara_rd_i),
    .alert_o  (alert_pull_o),
    .set_evt_o(set_evt),
    .clr_evt_o(clr_evt)
  );

  thalert_status #(.N_SRC(N_SRC)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (fault_i),
    .rd_i  (stat_rd_i),
    .stat_o(status_o)
  );

  thalert_resp #(.ADDR_W(ADDR_W)) u_resp (
    .latched_i(alert_pull_o),
    .addr_i   (dev_addr_i),
    .byte_o   (ara_byte_o)
  );
endmodule

// File: rtl/thermal_alert_ctl_chk.sv
module thermal_alert_ctl_chk #(
  parameter int N_SRC  = 3,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  fault_i,
  input logic              irq_en_i,
  input logic              ara_rd_i,
  input logic              stat_rd_i,
  input logic [ADDR_W-1:0] dev_addr_i,
  input logic              alert_pull_o,
  input logic [N_SRC-1:0]  status_o,
  input logic [ADDR_W:0]   ara_byte_o,
  input logic              fault_any,
  input logic              set_evt,
  input logic              clr_evt
);
  AST_SET_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_i && (|fault_i)) |=> alert_pull_o); // R2
  AST_SET_EVT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> $rose(alert_pull_o)); // R2
  AST_HOLD_NO_ARA: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_pull_o && !ara_rd_i) |=> alert_pull_o); // R3
  AST_ARA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !alert_pull_o); // R4
  AST_ARA_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_pull_o && ara_rd_i && fault_any) |=> alert_pull_o); // R5
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_pull_o && !irq_en_i) |=> !alert_pull_o); // R6
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R7
  AST_STAT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(fault_i)) == $past(fault_i))); // R7
  AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i |=> (status_o == $past(fault_i))); // R8
  AST_RESP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    alert_pull_o |-> (ara_byte_o == {dev_addr_i, 1'b0})); // R9
  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_pull_o |-> (&ara_byte_o)); // R9
endmodule

bind thermal_alert_ctl thermal_alert_ctl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/thermal_alert_ctl_tb.sv
module thermal_alert_ctl_tb;
  localparam int N_SRC  = 3;
  localparam int ADDR_W = 7;
  localparam int NVEC   = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_SRC-1:0]  fault_i = '0;
  logic              irq_en_i = 1'b0;
  logic              ara_rd_i = 1'b0;
  logic              stat_rd_i = 1'b0;
  logic [ADDR_W-1:0] dev_addr_i = 7'h4C;
  logic              alert_pull_o;
  logic [N_SRC-1:0]  status_o;
  logic [ADDR_W:0]   ara_byte_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;  // 250 MHz

  thermal_alert_ctl #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_dut (.*);

  // {open, lo, hi, en, ara, srd, exp_alert, exp_status[2:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b001_1_0_0_1_001, // R2 upper fault raises alert
    10'b000_1_0_0_1_001, // R3 fault gone, held
    10'b000_1_0_1_1_000, // R8 status read clears, R3 alert stays
    10'b000_0_0_0_1_000, // R3 mask does not clear
    10'b000_0_1_0_0_000, // R4 poll clears
    10'b010_0_0_0_0_010, // R6 masked lower fault, R7 status still set
    10'b010_0_1_0_0_010, // R6 poll while idle does not raise
    10'b100_1_0_0_1_110, // R2 open diode raises
    10'b100_1_1_0_1_110, // R5 persists across poll
    10'b100_0_1_0_1_110, // R5 persists while masked
    10'b000_0_1_0_0_110, // R4 clears, R7 sticky
    10'b001_1_0_1_1_001, // R8 read keeps active source
    10'b011_1_1_0_1_011, // R5 two faults at poll
    10'b000_0_1_0_0_011  // R4 final clear
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 7:      return "R2";
      1, 3:      return "R3";
      4, 10, 13: return "R4";
      8, 9, 12:  return "R5";
      5, 6:      return "R6";
      default:   return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input logic al, input logic [6:0] a);
    return al ? {a, 1'b0} : 8'hFF;
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin : main
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", alert_pull_o, 0);
    check("R1", status_o, 0);
    check("R1", ara_byte_o, 8'hFF);
    rst_n = 1'b1;
    step();
    check("R1", alert_pull_o, 0);
    check("R1", status_o, 0);

    for (int i = 0; i < NVEC; i++) begin
      {fault_i, irq_en_i, ara_rd_i, stat_rd_i} = VEC[i][9:4];
      step();
      check(vec_req(i), alert_pull_o, VEC[i][3]);
      check((i == 5 || i == 10) ? "R7" : vec_req(i), status_o, VEC[i][2:0]);
      check("R9", ara_byte_o, exp_byte(VEC[i][3], dev_addr_i));
      {fault_i, irq_en_i, ara_rd_i, stat_rd_i} = '0;
    end

    // R7 each source maps to its own bit, masked or not
    stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
    check("R8", status_o, 3'b000);
    fault_i = 3'b100; step(); fault_i = '0;
    check("R7", status_o, 3'b100);
    check("R6", alert_pull_o, 0);

    // R9 address change while latched is reflected in the byte
    irq_en_i = 1'b1; fault_i = 3'b010; step(); fault_i = '0;
    check("R2", alert_pull_o, 1);
    dev_addr_i = 7'h2B;
    #1;
    check("R9", ara_byte_o, 8'h56);
    // R3 status read does not clear the alert
    stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
    check("R3", alert_pull_o, 1);
    check("R8", status_o, 3'b000);

    // R1 mid-run reset clears everything
    fault_i = 3'b001; step(); fault_i = '0;
    rst_n = 1'b0; #1;
    check("R1", alert_pull_o, 0);
    check("R1", status_o, 0);
    check("R1", ara_byte_o, 8'hFF);
    step(); rst_n = 1'b1; step();
    check("R1", alert_pull_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule